// File: doc/BRIEF.md
# Alternate Pattern Switch Controller

This block steers a bit-serial pattern generator between two stored patterns of equal length, called A and B, and can hold the serial data at zero. It produces the read address into the pattern store, a flag that says which of the two patterns is being read, and a gate flag that tells the downstream serialiser to send zeros in place of pattern data. Pattern changes take effect only at the first bit of a new pass through the pattern, so the data stream never contains a partly played pattern.

An external auxiliary line drives the choice. It is synchronised into the bit clock domain first. Its effect depends on a mode input.
- In one-shot mode, a rising edge on the line asks for a single pass of B inside a stream of A. A panel strobe or a register strobe makes the same request.
- In alternate mode, the level of the line picks the pattern at each pattern end.
- In any mode other than alternate, a high level on the line gates the output to zero. Gating starts and stops on 32-bit block boundaries.

Top module: `alt_pattern_switch`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `rdAddr` is 0, `patSelB` is 0 (pattern A) and `gateZero` is 0.
- R2: `rdAddr` advances by one on every clock. After the value `patLen`-1 it returns to 0. `patLen` is a multiple of 512 and at most 2^24.
- R3: `patSelB` (0 = A, 1 = B) changes only on a clock edge that moves `rdAddr` to 0, so every change happens at the end of a full pattern.
- R4: In one-shot mode (`mode` = 2'd1), a rising edge of `auxIn` during an A pass makes the next pass B. The pass after that is A again, so exactly one copy of B is inserted.
- R5: In one-shot mode, a one-cycle pulse on `panelCmd` or on `regCmd` has the same effect as a rising edge of `auxIn`.
- R6: In one-shot mode, a request that arrives while B is playing is held. When B ends, A plays one full pass, and the pass after that is B.
- R7: In alternate mode (`mode` = 2'd2), the synchronised `auxIn` level at a pattern end selects the next pass: high selects B and low selects A.
- R8: When `mode` is not 2'd2, a high `auxIn` sets `gateZero` to 1. The rise happens on the first address that is a multiple of 32 after the level has passed the two-flop synchroniser.
- R9: After `auxIn` returns low, `gateZero` falls on the next address that is a multiple of 32, once the synchroniser delay has passed.
- R10: In alternate mode a high `auxIn` never sets `gateZero`. In mode 2'd0 (none) and in mode 2'd3, the strobes and `auxIn` leave `patSelB` at 0.
- R11: `gateZero` changes only on a clock edge that moves `rdAddr` to a multiple of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| auxIn | input | 1 | Asynchronous auxiliary control line |
| patLen | input | ADDR_W+1 | Pattern length in bits, held constant while running |
| mode | input | 2 | 0 none, 1 one-shot, 2 alternate, 3 treated as none |
| panelCmd | input | 1 | One-cycle panel request for a single B pass |
| regCmd | input | 1 | One-cycle register request for a single B pass |
| rdAddr | output | ADDR_W | Bit address into the selected pattern |
| patSelB | output | 1 | 0 reads pattern A, 1 reads pattern B |
| gateZero | output | 1 | 1 forces the serial data to zero |

## Verification
The assertions assume three things about the inputs:
- `patLen` is a multiple of 512 and does not change after reset, so every pattern end also falls on a 32-bit block boundary.
- `mode` is static within a pattern pass.
- Pulses on the asynchronous `auxIn` last long enough to pass the synchroniser.

The stimulus keeps to these assumptions. It uses a fixed length of 512. It changes mode only outside the windows being checked. It drives every `auxIn` and strobe change at a negative edge, at an address far from both pattern ends and block ends, so the expected boundary does not depend on the exact synchroniser latency.

// File: rtl/alt_sw_pkg.sv
package alt_sw_pkg;

  typedef enum logic [1:0] {
    MODE_NONE    = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_ALT     = 2'd2,
    MODE_RSVD    = 2'd3
  } swMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSel;   // pattern end: latch nextSelB
    logic nextSelB;
    logic loadGate;  // block end: latch nextGate
    logic nextGate;
  } swStrobe_t;

endpackage

// File: rtl/alt_sw_sync.sv
module alt_sw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stageQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= 1'b0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[i] <= 1'b0;
          else       stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/alt_sw_ctrl.sv
module alt_sw_ctrl
  import alt_sw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      auxSync,
  input  swMode_e   mode,
  input  logic      panelCmd,
  input  logic      regCmd,
  input  logic      patEnd,
  input  logic      blkEnd,
  input  logic      curSelB,
  output swStrobe_t strb
);
  logic auxPrev;
  logic auxRise;
  logic reqNow;
  logic takeB;
  logic pendingB;

  assign auxRise = auxSync & ~auxPrev;
  assign reqNow  = (mode == MODE_ONESHOT) & (auxRise | panelCmd | regCmd);
  // a held request is only taken at the end of an A pass
  assign takeB   = patEnd & ~curSelB & pendingB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxPrev  <= 1'b0;
      pendingB <= 1'b0;
    end else begin
      auxPrev <= auxSync;
      if (mode != MODE_ONESHOT) pendingB <= 1'b0;
      else if (reqNow)          pendingB <= 1'b1;
      else if (takeB)           pendingB <= 1'b0;
    end
  end

  always_comb begin
    strb.loadSel  = patEnd;
    strb.loadGate = blkEnd;
    strb.nextGate = auxSync & (mode != MODE_ALT);
    unique case (mode)
      MODE_ALT:     strb.nextSelB = auxSync;
      MODE_ONESHOT: strb.nextSelB = takeB;
      default:      strb.nextSelB = 1'b0;
    endcase
  end
endmodule

// File: rtl/alt_sw_datapath.sv
module alt_sw_datapath
  import alt_sw_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int GATE_BLK = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W:0]   patLen,
  input  swStrobe_t         strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              patSelB,
  output logic              gateZero,
  output logic              patEnd,
  output logic              blkEnd
);
  localparam int BLK_W = $clog2(GATE_BLK);

  assign patEnd = ({1'b0, rdAddr} == (patLen - 1'b1));
  assign blkEnd = &rdAddr[BLK_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr   <= '0;
      patSelB  <= 1'b0;
      gateZero <= 1'b0;
    end else begin
      rdAddr <= patEnd ? '0 : rdAddr + 1'b1;
      if (strb.loadSel)  patSelB  <= strb.nextSelB;
      if (strb.loadGate) gateZero <= strb.nextGate;
    end
  end
endmodule

// File: rtl/alt_pattern_switch.sv
module alt_pattern_switch
  import alt_sw_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int GATE_BLK    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              auxIn,
  input  logic [ADDR_W:0]   patLen,
  input  logic [1:0]        mode,
  input  logic              panelCmd,
  input  logic              regCmd,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              patSelB,
  output logic              gateZero
);
  logic      auxSync;
  logic      patEnd;
  logic      blkEnd;
  swStrobe_t strb;
  swMode_e   modeE;

  assign modeE = swMode_e'(mode);

  alt_sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(auxIn), .syncOut(auxSync)
  );

  alt_sw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .auxSync(auxSync), .mode(modeE),
    .panelCmd(panelCmd), .regCmd(regCmd), .patEnd(patEnd),
    .blkEnd(blkEnd), .curSelB(patSelB), .strb(strb)
  );

  alt_sw_datapath #(.ADDR_W(ADDR_W), .GATE_BLK(GATE_BLK)) u_dp (
    .clk(clk), .rstN(rstN), .patLen(patLen), .strb(strb),
    .rdAddr(rdAddr), .patSelB(patSelB), .gateZero(gateZero),
    .patEnd(patEnd), .blkEnd(blkEnd)
  );
endmodule

// File: rtl/alt_pattern_switch_chk.sv
module alt_pattern_switch_chk #(
  parameter int ADDR_W   = 24,
  parameter int GATE_BLK = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        mode,
  input logic [ADDR_W:0]   patLen,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              patSelB,
  input logic              gateZero,
  input logic              auxSync
);
  localparam int BLK_W = $clog2(GATE_BLK);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr != '0) |-> (rdAddr == $past(rdAddr) + 1'b1));

  // R2
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, rdAddr} == patLen - 1'b1) |=> (rdAddr == '0));

  // R3
  sel_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(patSelB) |-> (rdAddr == '0));

  // R11
  gate_at_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gateZero) |-> (rdAddr[BLK_W-1:0] == '0));

  // R7
  alt_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && {1'b0, rdAddr} == patLen - 1'b1) |=> (patSelB == $past(auxSync)));
endmodule

bind alt_pattern_switch alt_pattern_switch_chk #(.ADDR_W(ADDR_W), .GATE_BLK(GATE_BLK)) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .patLen(patLen), .rdAddr(rdAddr),
  .patSelB(patSelB), .gateZero(gateZero), .auxSync(auxSync)
);

// File: tb/alt_pattern_switch_tb.sv
module alt_pattern_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int LEN        = 512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              auxIn = 1'b0;
  logic [ADDR_W:0]   patLen = (ADDR_W+1)'(LEN);
  logic [1:0]        mode = 2'd0;
  logic              panelCmd = 1'b0;
  logic              regCmd = 1'b0;
  logic [ADDR_W-1:0] rdAddr;
  logic              patSelB;
  logic              gateZero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alt_pattern_switch #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .auxIn(auxIn), .patLen(patLen), .mode(mode),
    .panelCmd(panelCmd), .regCmd(regCmd), .rdAddr(rdAddr),
    .patSelB(patSelB), .gateZero(gateZero)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitAddr(input int a);
    @(negedge clk);
    while (int'(rdAddr) != a) @(negedge clk);
  endtask

  task automatic pulseAux();
    auxIn = 1'b1;
    repeat (3) @(negedge clk);
    auxIn = 1'b0;
  endtask

  task automatic expectPass(input int sel, input string req);
    waitAddr(0);
    check(patSelB == sel[0], req, int'(patSelB), sel);
  endtask

  task automatic testReset();
    #(CLK_PERIOD*2 + 1);
    check(rdAddr == '0 && !patSelB && !gateZero, "R1 in reset", int'(rdAddr), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(rdAddr == 24'd1, "R1 first count", int'(rdAddr), 1);
    check(!patSelB && !gateZero, "R1 sel/gate", int'({patSelB, gateZero}), 0);
  endtask

  task automatic testWrap();
    waitAddr(LEN-1);
    @(negedge clk);
    check(rdAddr == '0, "R2 wrap", int'(rdAddr), 0);
    @(negedge clk);
    check(rdAddr == 24'd1, "R2 step", int'(rdAddr), 1);
  endtask

  task automatic testOneShot();
    mode = 2'd1;
    waitAddr(100);
    pulseAux();
    expectPass(1, "R4 B inserted");
    expectPass(0, "R4 A resumes");
    expectPass(0, "R4 single copy");
  endtask

  task automatic testCmds();
    waitAddr(100);
    panelCmd = 1'b1; @(negedge clk); panelCmd = 1'b0;
    expectPass(1, "R5 panel B");
    expectPass(0, "R5 panel A");
    waitAddr(100);
    regCmd = 1'b1; @(negedge clk); regCmd = 1'b0;
    expectPass(1, "R5 reg B");
    expectPass(0, "R5 reg A");
  endtask

  task automatic testHeld();
    waitAddr(100);
    pulseAux();
    expectPass(1, "R6 first B");
    waitAddr(100);
    regCmd = 1'b1; @(negedge clk); regCmd = 1'b0;
    expectPass(0, "R6 A after B");
    expectPass(1, "R6 held B");
    expectPass(0, "R6 back to A");
  endtask

  task automatic testAlt();
    mode = 2'd2;
    waitAddr(100);
    auxIn = 1'b1;
    expectPass(1, "R7 high selects B");
    waitAddr(64);
    check(!gateZero, "R10 no gate in alternate", int'(gateZero), 0);
    expectPass(1, "R7 B kept");
    waitAddr(100);
    auxIn = 1'b0;
    expectPass(0, "R7 low selects A");
  endtask

  task automatic testGate();
    mode = 2'd0;
    waitAddr(40);
    auxIn = 1'b1;
    waitAddr(63);
    check(!gateZero, "R8 before boundary", int'(gateZero), 0);
    @(negedge clk);
    check(gateZero, "R8 gate at 64", int'(gateZero), 1);
    check(!patSelB, "R10 gate keeps A", int'(patSelB), 0);
    waitAddr(200);
    auxIn = 1'b0;
    waitAddr(223);
    check(gateZero, "R9 held to boundary", int'(gateZero), 1);
    @(negedge clk);
    check(!gateZero, "R9 release at 224", int'(gateZero), 0);
  endtask

  task automatic testIgnored();
    mode = 2'd0;
    waitAddr(100);
    panelCmd = 1'b1; regCmd = 1'b1; @(negedge clk);
    panelCmd = 1'b0; regCmd = 1'b0;
    expectPass(0, "R10 none ignores strobes");
    mode = 2'd3;
    waitAddr(100);
    regCmd = 1'b1; @(negedge clk); regCmd = 1'b0;
    expectPass(0, "R10 mode 3 ignores strobes");
  endtask

  initial begin
    testReset();
    testWrap();
    testOneShot();
    testCmds();
    testHeld();
    testAlt();
    testGate();
    testIgnored();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule